// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block sits in front of a synchronous memory array or memory controller and produces the address for each beat of a four-beat burst. When a transfer starts, the external address is taken as the first beat. On each later beat the block computes the address itself from a two-bit beat counter. Only the two least significant address bits step. The upper bits stay fixed at the value captured when the burst started.

Two orderings are available, chosen by a static order input. In the linear order the low bits count upward modulo four from the starting offset. In the interleaved order the low bits are the starting offset XOR the beat count. Both orderings return to the starting address on the fifth beat. An active-low clock enable stalls the whole block, and the address and beat count keep their values while it is stalled. The output is registered, so the address for a command applied at one edge is present from that edge until the next edge that changes it.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active (`rstN` low) and right after it, `addrOut` is all zeros.
- R2: At an enabled edge (`clkEnN` low) with `advance` low, `addrOut` becomes `addrIn` after that edge, and the beat count restarts at zero.
- R3: With `orderSel` = 0 (linear), after n enabled edges with `advance` high since the last load, `addrOut[1:0]` equals (start + n) mod 4, where start is the loaded `addrIn[1:0]`.
- R4: With `orderSel` = 1 (interleaved), after n enabled advance edges since the last load, `addrOut[1:0]` equals start XOR (n mod 4). For example, start 2'b01 gives 01, 00, 11, 10.
- R5: The fourth advance after a load returns `addrOut` to the loaded address, and further advances repeat the same sequence.
- R6: The upper bits `addrOut[ADDR_W-1:2]` change only at a load edge. During advances, `addrIn` has no effect on `addrOut`.
- R7: An edge with `clkEnN` high leaves `addrOut` and the beat count unchanged, whatever `advance` and `addrIn` are. The next enabled advance continues the sequence from where it stopped.
- R8: A load in the middle of a burst abandons that burst. The following advances step from the newly loaded offset, starting with count 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low; high stalls the block |
| advance | input | 1 | 0 = load `addrIn` as a new start, 1 = step to the next beat |
| orderSel | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| addrIn | input | ADDR_W | External start address |
| addrOut | output | ADDR_W | Current burst address, registered |

## Verification
The embedded properties take `orderSel` to be a board-level strap. It is expected to change only at a load edge, never in the middle of a burst, and the step property depends on this.

The stimulus keeps to that rule. The bench table and the sweep over every start offset change the order input only at the vector that performs a load. Reset is released away from the clock edge, so the reset properties see a clean start.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Strobes from the control decode to the address datapath.
  typedef struct packed {
    logic loadEn;   // capture a new start address
    logic stepEn;   // advance the beat counter
    logic holdEn;   // stalled edge, nothing may move
  } burstStrobe_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clkEnN,
  input  logic         advance,
  output burstStrobe_t strobe
);

  always_comb begin
    strobe.holdEn = clkEnN;
    strobe.loadEn = !clkEnN && !advance;
    strobe.stepEn = !clkEnN && advance;
  end

  // At most one action per edge; a stall excludes both (R7)
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.loadEn, strobe.stepEn, strobe.holdEn}) == 1); // R7

endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobe_t      strobe,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [BURST_W-1:0] startQ;
  logic [BURST_W-1:0] cntQ;
  logic [BURST_W-1:0] cntNext;
  logic [BURST_W-1:0] lowNext;
  logic [ADDR_W-1:0]  addrQ;

  assign cntNext = cntQ + 1'b1;

  // Offset of the next beat in the selected order (R3, R4)
  always_comb begin
    if (orderSel) lowNext = startQ ^ cntNext;
    else          lowNext = startQ + cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= '0;
      cntQ   <= '0;
      addrQ  <= '0;
    end else if (strobe.loadEn) begin
      startQ <= addrIn[BURST_W-1:0];
      cntQ   <= '0;
      addrQ  <= addrIn;
    end else if (strobe.stepEn) begin
      cntQ                 <= cntNext;
      addrQ[BURST_W-1:0]   <= lowNext;
    end
  end

  assign addrOut = addrQ;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> (addrOut == $past(addrIn))); // R2
  AST_LOAD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> (cntQ == '0)); // R8
  AST_STEP_COUNTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepEn |=> (cntQ == $past(cntQ) + 1'b1)); // R5
  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> $stable(addrOut[ADDR_W-1:BURST_W])); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.holdEn |=> ($stable(addrOut) && $stable(cntQ))); // R7
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepEn && !orderSel) |=>
      (addrOut[BURST_W-1:0] == startQ + cntQ)); // R3

  if (UPPER_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed BURST_W");
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              advance,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);

  burstStrobe_t strobe;

  burst_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkEnN  (clkEnN),
    .advance (advance),
    .strobe  (strobe)
  );

  burst_addr_dp #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .orderSel (orderSel),
    .addrIn   (addrIn),
    .addrOut  (addrOut)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |-> (addrOut == '0)); // R1

endmodule

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

  localparam int ADDR_W = 20;
  localparam int NVEC   = 19;
  localparam int VEC_W  = 4 + 3 + 2 * ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clkEnN = 1'b1;
  logic              advance = 1'b0;
  logic              orderSel = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [ADDR_W-1:0] addrOut;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) i_burst_addr_gen (
    .clk      (clk),
    .rstN     (rstN),
    .clkEnN   (clkEnN),
    .advance  (advance),
    .orderSel (orderSel),
    .addrIn   (addrIn),
    .addrOut  (addrOut)
  );

  // Vector: {req, orderSel, clkEnN, advance, addrIn, expected addrOut}
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {4'd2, 3'b000, 20'hA5C31, 20'hA5C31}, // R2 load linear
    {4'd3, 3'b001, 20'h00000, 20'hA5C32}, // R3
    {4'd3, 3'b001, 20'h00000, 20'hA5C33}, // R3
    {4'd3, 3'b001, 20'h00000, 20'hA5C30}, // R3 wrap through 0
    {4'd5, 3'b001, 20'h00000, 20'hA5C31}, // R5 fifth beat
    {4'd5, 3'b001, 20'h00000, 20'hA5C32}, // R5 repeat
    {4'd7, 3'b010, 20'hFFFFF, 20'hA5C32}, // R7 stalled load ignored
    {4'd7, 3'b011, 20'h00000, 20'hA5C32}, // R7 stalled advance
    {4'd7, 3'b001, 20'h00000, 20'hA5C33}, // R7 continues
    {4'd2, 3'b100, 20'h12346, 20'h12346}, // R2 load interleaved
    {4'd4, 3'b101, 20'h00000, 20'h12347}, // R4 10^01
    {4'd4, 3'b101, 20'h00000, 20'h12344}, // R4 10^10
    {4'd4, 3'b101, 20'h00000, 20'h12345}, // R4 10^11
    {4'd5, 3'b101, 20'h00000, 20'h12346}, // R5 interleaved wrap
    {4'd2, 3'b100, 20'h0BEE1, 20'h0BEE1}, // R2
    {4'd4, 3'b101, 20'h00000, 20'h0BEE0}, // R4
    {4'd8, 3'b100, 20'h77773, 20'h77773}, // R8 mid-burst reload
    {4'd8, 3'b101, 20'hFFFF0, 20'h77772}, // R8 and R6 addrIn ignored
    {4'd6, 3'b101, 20'h12345, 20'h77771}  // R6
  };

  task automatic check(input string tag, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addrOut actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  // Drive on falling edge; the result is visible at the next falling edge.
  task automatic step(input logic o, input logic en, input logic a,
                      input logic [ADDR_W-1:0] ai);
    orderSel = o; clkEnN = en; advance = a; addrIn = ai;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 during reset", addrOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", addrOut, '0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [VEC_W-1:0] v;
      v = VECS[i];
      step(v[VEC_W-5], v[VEC_W-6], v[VEC_W-7],
           v[2*ADDR_W-1:ADDR_W]);
      check($sformatf("R%0d vec%0d", v[VEC_W-1:VEC_W-4], i),
            addrOut, v[ADDR_W-1:0]);
    end

    // Sweep every start offset in both orders: R3 R4 R5
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        logic [ADDR_W-1:0] base;
        base = {18'h2C0F0 + 18'(s), 2'(s)};
        step(o[0], 1'b0, 1'b0, base);
        check("R2 sweep load", addrOut, base);
        for (int n = 1; n <= 6; n++) begin
          logic [1:0] lo;
          lo = o[0] ? (2'(s) ^ 2'(n)) : 2'(s + n);
          step(o[0], 1'b0, 1'b1, ~base);
          check(o[0] ? "R4 sweep" : "R3 sweep", addrOut,
                {base[ADDR_W-1:2], lo});
        end
      end
    end

    // Long stall mid-burst: R7
    step(1'b0, 1'b0, 1'b0, 20'h40002);
    step(1'b0, 1'b0, 1'b1, 20'h0);
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b1, k[0], 20'hABCDE);
      check("R7 long stall", addrOut, 20'h40003);
    end
    step(1'b0, 1'b0, 1'b1, 20'h0);
    check("R7 resume", addrOut, 20'h40000);

    // Reset in the middle of a burst: R1
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", addrOut, '0);
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b1, 20'h0);
    check("R3 step from reset", addrOut, 20'h00001);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule